// File: doc/BRIEF.md
# Packed 12-bit Coefficient Unpacker

This block turns a byte-packed public-key region into 12-bit polynomial coefficients. A single start pulse, together with a polynomial count k, launches a walk over k polynomials. Each polynomial is stored as 384 consecutive bytes, which form 128 groups of three bytes. Every group is split into two 12-bit coefficients. The bytes come from an external synchronous byte memory that returns data one cycle after the address is presented. The coefficients leave through a registered write port (enable, address, data) into an external coefficient memory.

Each group takes a fixed schedule of five cycles. In the first three cycles the block presents the three byte addresses in turn and captures each byte one cycle after its address was driven. In the last two cycles it emits the two coefficients. After the final group of the last polynomial, a done flag rises and stays high until the next start.

The block does not reduce the coefficients, does not check their range, and does not arbitrate for the coefficient memory.

Top module: `coef_unpack12`

## Requirements
- R1: While reset is asserted and afterwards until the first start, done_o is 0 and wr_en_o is 0.
- R2: For a group of bytes b0, b1, b2, the first coefficient written is {b1[3:0], b0}: bits 7..0 hold b0 and bits 11..8 hold the low nibble of b1.
- R3: The second coefficient written for the same group is {b2, b1[7:4]}: bits 3..0 hold the high nibble of b1 and bits 11..4 hold b2.
- R4: Take j as the number of clock edges since the start edge, j < 640*k. Let m = j/5, poly = m/128, group = m%128 and phase = j%5. Then rd_addr_o equals poly*384 + group*3 + min(phase, 2). The address therefore stays on the third byte during both write phases.
- R5: The coefficients for group g of polynomial p are written at addresses p*256 + 2g and p*256 + 2g + 1. Over a run, the write addresses climb by one from 0 to 256*k - 1.
- R6: wr_en_o is high exactly when j%5 == 4, or when j%5 == 0 with j > 0. That is two adjacent cycles per group, followed by three idle cycles.
- R7: done_o rises 640*k cycles after the start edge, together with the last write. After that it stays high and no further write occurs. A run makes exactly 256*k writes.
- R8: A start pulse clears done_o and restarts the walk from polynomial 0, group 0, phase 0. This also applies to a start pulse that arrives in the middle of a run.
- R9: k (2, 3 or 4) is sampled only on the start cycle, so a change of k_i during a run has no effect on its length or on its writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins (or restarts) a walk |
| k_i | input | 3 | Number of polynomials, sampled on start |
| rd_addr_o | output | 11 | Byte memory read address |
| rd_data_i | input | 8 | Byte memory read data, one cycle after the address |
| wr_en_o | output | 1 | Coefficient write enable |
| wr_addr_o | output | 10 | Coefficient write address |
| wr_data_o | output | 12 | Coefficient write data |
| done_o | output | 1 | Walk complete |

## Verification
Two events coincide in a single cycle at the end of a run: the write of the final group's second coefficient and the rise of done_o. The bench follows every cycle of the walk against the j-based schedule. It requires done_o to go high exactly on the cycle that carries the 256*k-th write, and requires no write after that point. A second coincidence arises when a start pulse arrives while the coefficient port is active. The bench restarts a run in its middle with different data and a different k. It then requires the write log to begin cleanly at address 0, the cycle schedule to restart at phase 0, and every coefficient of the new run to match its packed source.

// File: rtl/unpack12_pkg.sv
package unpack12_pkg;

    // Five-step schedule of one three-byte group.
    typedef enum logic [2:0] {
        PH_FETCH0  = 3'd0,  // drive address of byte 0
        PH_FETCH1  = 3'd1,  // capture byte 0, drive byte 1
        PH_FETCH2  = 3'd2,  // capture byte 1, drive byte 2
        PH_EMIT_LO = 3'd3,  // capture byte 2, emit first coefficient
        PH_EMIT_HI = 3'd4   // emit second coefficient, advance group
    } phase_t;

    localparam int BYTES_PER_GROUP = 3;
    localparam int COEFS_PER_GROUP = 2;

endpackage

// File: rtl/unpack12_walk.sv
module unpack12_walk
    import unpack12_pkg::*;
#(
    parameter int GROUPS = 128,
    parameter int MAX_K  = 4,
    localparam int BPP   = GROUPS * BYTES_PER_GROUP,
    localparam int CPP   = GROUPS * COEFS_PER_GROUP,
    localparam int BA_W  = $clog2(MAX_K * BPP),
    localparam int CA_W  = $clog2(MAX_K * CPP),
    localparam int KW    = $clog2(MAX_K + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [KW-1:0]   k_i,
    output logic [BA_W-1:0] rd_addr_o,
    output logic            cap0_o,
    output logic            cap1_o,
    output logic            emit_lo_o,
    output logic            emit_hi_o,
    output logic [CA_W-1:0] wbase_o,
    output logic            done_o
);
    localparam int PI_W = $clog2(MAX_K);
    localparam int GI_W = $clog2(GROUPS);

    typedef struct packed {
        logic            run;
        logic            done;
        logic [KW-1:0]   klim;
        logic [PI_W-1:0] poly;
        logic [GI_W-1:0] grp;
        phase_t          ph;
    } walk_t;

    walk_t s_d, s_q;
    logic  last_grp, last_poly;
    logic [1:0] bidx;

    assign last_grp  = (s_q.grp == GI_W'(GROUPS - 1));
    assign last_poly = ((KW'(s_q.poly) + KW'(1)) == s_q.klim);

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.run  = 1'b1;
            s_d.done = 1'b0;
            s_d.klim = k_i;
            s_d.poly = '0;
            s_d.grp  = '0;
            s_d.ph   = PH_FETCH0;
        end else if (s_q.run) begin
            unique case (s_q.ph)
                PH_FETCH0:  s_d.ph = PH_FETCH1;
                PH_FETCH1:  s_d.ph = PH_FETCH2;
                PH_FETCH2:  s_d.ph = PH_EMIT_LO;
                PH_EMIT_LO: s_d.ph = PH_EMIT_HI;
                PH_EMIT_HI: begin
                    s_d.ph = PH_FETCH0;
                    if (last_grp) begin
                        s_d.grp = '0;
                        if (last_poly) begin
                            s_d.run  = 1'b0;
                            s_d.done = 1'b1;
                        end else begin
                            s_d.poly = s_q.poly + PI_W'(1);
                        end
                    end else begin
                        s_d.grp = s_q.grp + GI_W'(1);
                    end
                end
                default:    s_d.ph = PH_FETCH0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.run  <= 1'b0;
            s_q.done <= 1'b0;
            s_q.klim <= '0;
            s_q.poly <= '0;
            s_q.grp  <= '0;
            s_q.ph   <= PH_FETCH0;
        end else begin
            s_q <= s_d;
        end
    end

    // Byte index within the group; held on byte 2 through both emit phases.
    always_comb begin
        unique case (s_q.ph)
            PH_FETCH0: bidx = 2'd0;
            PH_FETCH1: bidx = 2'd1;
            default:   bidx = 2'd2;
        endcase
    end

    assign rd_addr_o = BA_W'(s_q.poly) * BA_W'(BPP)
                     + BA_W'(s_q.grp) * BA_W'(BYTES_PER_GROUP)
                     + BA_W'(bidx);
    assign wbase_o   = CA_W'(s_q.poly) * CA_W'(CPP)
                     + CA_W'(s_q.grp) * CA_W'(COEFS_PER_GROUP);

    assign cap0_o    = s_q.run && !start_i && (s_q.ph == PH_FETCH1);
    assign cap1_o    = s_q.run && !start_i && (s_q.ph == PH_FETCH2);
    assign emit_lo_o = s_q.run && !start_i && (s_q.ph == PH_EMIT_LO);
    assign emit_hi_o = s_q.run && !start_i && (s_q.ph == PH_EMIT_HI);
    assign done_o    = s_q.done;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && s_q.ph == PH_EMIT_HI) |-> $stable(rd_addr_o)); // R4

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && s_q.ph == PH_FETCH0 && rd_addr_o == '0)); // R8

endmodule

// File: rtl/unpack12_join.sv
module unpack12_join #(
    parameter int BYTE_W = 8,
    parameter int CA_W   = 10,
    localparam int NIB   = BYTE_W / 2,
    localparam int COEF_W = BYTE_W + NIB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  logic              cap0_i,
    input  logic              cap1_i,
    input  logic              emit_lo_i,
    input  logic              emit_hi_i,
    input  logic [CA_W-1:0]   wbase_i,
    output logic              wr_en_o,
    output logic [CA_W-1:0]   wr_addr_o,
    output logic [COEF_W-1:0] wr_data_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
        logic [BYTE_W-1:0] b2;
        logic              we;
        logic [CA_W-1:0]   wa;
        logic [COEF_W-1:0] wd;
    } join_t;

    join_t j_d, j_q;

    always_comb begin
        j_d    = j_q;
        j_d.we = 1'b0;
        if (cap0_i) j_d.b0 = rd_data_i;
        if (cap1_i) j_d.b1 = rd_data_i;
        if (emit_lo_i) begin
            j_d.b2 = rd_data_i;
            j_d.we = 1'b1;
            j_d.wa = wbase_i;
            j_d.wd = {j_q.b1[NIB-1:0], j_q.b0};
        end
        if (emit_hi_i) begin
            j_d.we = 1'b1;
            j_d.wa = wbase_i + CA_W'(1);
            j_d.wd = {j_q.b2, j_q.b1[BYTE_W-1:NIB]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            j_q <= '0;
        end else begin
            j_q <= j_d;
        end
    end

    assign wr_en_o   = j_q.we;
    assign wr_addr_o = j_q.wa;
    assign wr_data_o = j_q.wd;

    AST_WADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (j_q.we && $past(j_q.we)) |-> (j_q.wa == $past(j_q.wa) + CA_W'(1))); // R5

endmodule

// File: rtl/coef_unpack12.sv
module coef_unpack12 #(
    parameter int GROUPS = 128,
    parameter int MAX_K  = 4,
    parameter int BYTE_W = 8,
    localparam int COEF_W = BYTE_W + BYTE_W / 2,
    localparam int BA_W  = $clog2(MAX_K * GROUPS * 3),
    localparam int CA_W  = $clog2(MAX_K * GROUPS * 2),
    localparam int KW    = $clog2(MAX_K + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [KW-1:0]     k_i,
    output logic [BA_W-1:0]   rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [CA_W-1:0]   wr_addr_o,
    output logic [COEF_W-1:0] wr_data_o,
    output logic              done_o
);
    logic            cap0, cap1, emit_lo, emit_hi;
    logic [CA_W-1:0] wbase;

    unpack12_walk #(.GROUPS(GROUPS), .MAX_K(MAX_K)) walk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .k_i       (k_i),
        .rd_addr_o (rd_addr_o),
        .cap0_o    (cap0),
        .cap1_o    (cap1),
        .emit_lo_o (emit_lo),
        .emit_hi_o (emit_hi),
        .wbase_o   (wbase),
        .done_o    (done_o)
    );

    unpack12_join #(.BYTE_W(BYTE_W), .CA_W(CA_W)) join_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_data_i (rd_data_i),
        .cap0_i    (cap0),
        .cap1_i    (cap1),
        .emit_lo_i (emit_lo),
        .emit_hi_i (emit_hi),
        .wbase_i   (wbase),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o)
    );

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !wr_en_o); // R7

    AST_WE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wr_en_o) && !start_i) |=> wr_en_o); // R6

    AST_IDLE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !wr_en_o && !start_i && $past(!rst_n)) |=> !wr_en_o); // R1

endmodule

// File: tb/coef_unpack12_tb_top.sv
module coef_unpack12_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_K = 4;
    localparam int BPP = 384;
    localparam int CPP = 256;
    localparam int CYC_PER_POLY = 640;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  k_in = 3'd2;
    logic [10:0] rd_addr;
    logic [7:0]  rd_data = 8'd0;
    logic        wr_en;
    logic [9:0]  wr_addr;
    logic [11:0] wr_data;
    logic        done;

    logic [7:0]  bmem [0:MAX_K*BPP-1];
    logic [11:0] gold [0:MAX_K*CPP-1];
    logic [11:0] cmem [0:MAX_K*CPP-1];

    int tests = 0;
    int fails = 0;
    int wcount = 0;
    int order_err = 0;
    int exp_wa = 0;
    logic log_clr = 1'b0;

    coef_unpack12 dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .k_i(k_in),
        .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .done_o(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Byte memory model: one-cycle read latency.
    always @(posedge clk) rd_data <= bmem[rd_addr];

    // Coefficient memory model and write log.
    always @(posedge clk) begin
        if (log_clr) begin
            wcount    <= 0;
            order_err <= 0;
            exp_wa    <= 0;
        end else if (wr_en) begin
            if (int'(wr_addr) != exp_wa) order_err <= order_err + 1;
            cmem[wr_addr] <= wr_data;
            exp_wa <= exp_wa + 1;
            wcount <= wcount + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // mode 0 random, 1 all ones, 2 nibble-contrast pattern
    task automatic load(input int k, input int mode);
        for (int i = 0; i < k*CPP; i++) begin
            case (mode)
                1:       gold[i] = 12'hFFF;
                2:       gold[i] = i[0] ? 12'h0F0 : 12'hA5C;
                default: gold[i] = 12'($urandom);
            endcase
        end
        for (int m = 0; m < k*128; m++) begin
            bmem[3*m]   = gold[2*m][7:0];
            bmem[3*m+1] = {gold[2*m+1][3:0], gold[2*m][11:8]};
            bmem[3*m+2] = gold[2*m+1][11:4];
        end
    endtask

    task automatic pulse_start(input int k);
        @(negedge clk);
        start = 1'b1; k_in = 3'(k); log_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; log_clr = 1'b0;
    endtask

    task automatic run_full(input int k, input bit wiggle_k);
        int addr_err = 0, we_err = 0, early_done = 0, err_lo = 0, err_hi = 0;
        int total = k * CYC_PER_POLY;
        pulse_start(k);
        chk(done == 1'b0, "R8 done cleared by start", done, 0);
        for (int j = 0; j <= total; j++) begin
            int ph, m, ea;
            bit ewe;
            if (j > 0) @(negedge clk);
            if (wiggle_k && j == 7) k_in = (k == 4) ? 3'd2 : 3'd4;
            ph = j % 5;
            m = j / 5;
            ewe = (ph == 4) || (ph == 0 && j > 0);
            if (wr_en != ewe) we_err++;
            if (j < total) begin
                ea = (m / 128) * BPP + (m % 128) * 3 + ((ph > 2) ? 2 : ph);
                if (int'(rd_addr) != ea) addr_err++;
                if (done) early_done++;
            end
        end
        chk(done == 1'b1, "R7 done at 640*k cycles", done, 1);
        chk(early_done == 0, "R7 done not early", early_done, 0);
        chk(addr_err == 0, "R4 byte address schedule", addr_err, 0);
        chk(we_err == 0, "R6 write enable cadence", we_err, 0);
        repeat (20) @(negedge clk);
        chk(done == 1'b1, "R7 done holds", done, 1);
        chk(wcount == k*CPP, wiggle_k ? "R9 write count with k changed" : "R7 write count",
            wcount, k*CPP);
        chk(order_err == 0, "R5 write address order", order_err, 0);
        for (int i = 0; i < k*CPP; i++) begin
            if (cmem[i] !== gold[i]) begin
                if (i % 2 == 0) err_lo++; else err_hi++;
            end
        end
        chk(err_lo == 0, "R2 first coefficient packing", err_lo, 0);
        chk(err_hi == 0, "R3 second coefficient packing", err_hi, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && wr_en == 1'b0, "R1 outputs in reset", {done, wr_en}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(done == 1'b0, "R1 done idle after reset", done, 0);
        chk(wcount == 0, "R1 no writes before start", wcount, 0);
    endtask

    task automatic t_restart;
        load(2, 0);
        pulse_start(2);
        repeat (703) @(negedge clk);
        load(3, 0);
        run_full(3, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < MAX_K*CPP; i++) cmem[i] = '0;
        t_reset();
        load(2, 0); run_full(2, 1'b0);
        load(3, 1); run_full(3, 1'b0);
        load(4, 2); run_full(4, 1'b0);
        load(2, 0); run_full(2, 1'b1);   // R9
        load(4, 0); run_full(4, 1'b1);   // R9
        t_restart();                      // R8
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end
endmodule